// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers single-cycle interrupt request pulses from a set of peripheral sources. It picks one of them to present to a processor. Every source owns an 8-bit control byte. The byte packs a latched request flag, a mask flag and a three-bit priority level. Software reaches each byte over a small register bus, either as a whole byte or one bit at a time. A single-bit write leaves the other bits of the byte untouched.

A source is eligible when its flag is set and its mask is clear. Among eligible sources, the one with the numerically smallest level wins, and level 0 is the most urgent. When two eligible sources share a level, the one with the lower index wins. The interrupt line and the winner's index and level appear combinationally, in the same cycle as the state that produces them. The processor then pulses an acknowledge, which clears the flag of the presented source.

The asynchronous active-low reset passes through an internal two-stage synchronizer, so its release takes effect two clock edges later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control byte reads 0x47 (flag 0, mask 1, level 7), and the interrupt output is low.
- R2: Byte layout: bit 7 is the request flag, bit 6 is the mask, and bits 2..0 are the level. Bits 5..3 always read 0, and writes to them, whether as a byte or as a single bit, have no effect.
- R3: A request pulse on `irq_req_i[i]` sets flag i at that clock edge, whether or not the source is masked.
- R4: A source whose mask is 1 is never presented, and its flag stays set. Clearing the mask makes it eligible from the next cycle.
- R5: Among eligible sources, the smallest level value is presented, with 0 the highest priority and 7 the lowest.
- R6: Among eligible sources at the same level, the lowest index is presented.
- R7: `cpu_irq_o` is high exactly when at least one source is eligible. `cpu_src_o` and `cpu_lvl_o` then give the winner.
- R8: `cpu_ack_i` high while `cpu_irq_o` is high clears the presented source's flag at that edge. An acknowledge while `cpu_irq_o` is low changes nothing.
- R9: A new request on the presented source in the same cycle as its acknowledge wins, and the flag stays set.
- R10: With `reg_bitwise_i`=0 a write loads flag, mask and level from `reg_wdata_i`. With `reg_bitwise_i`=1 it puts `reg_bit_val_i` into the bit selected by `reg_bit_sel_i` and leaves the others unchanged.
- R11: Software can set or clear the flag through bit 7. A hardware request and a software clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | N_SRC | Per-source request pulses |
| reg_addr_i | input | SRC_W | Index of the control byte being accessed |
| reg_we_i | input | 1 | Write strobe |
| reg_bitwise_i | input | 1 | 1 selects a single-bit write, 0 a whole-byte write |
| reg_bit_sel_i | input | 3 | Bit position for a single-bit write |
| reg_bit_val_i | input | 1 | Value for a single-bit write |
| reg_wdata_i | input | 8 | Data for a whole-byte write |
| reg_rdata_o | output | 8 | Control byte at `reg_addr_i` (combinational) |
| cpu_irq_o | output | 1 | At least one eligible source |
| cpu_src_o | output | SRC_W | Index of the presented source |
| cpu_lvl_o | output | 3 | Level of the presented source |
| cpu_ack_i | input | 1 | Acknowledge of the presented source |

## Verification
On every cycle the assertions check several properties. The presented source must be eligible, and no eligible source may be more urgent or share its level at a lower index. The interrupt line must not be low while anything is eligible. Request pulses must latch, masked flags must persist, an acknowledge must clear exactly the presented flag, and the reserved bits must read zero.

Some behaviours can only be shown by the bench's scenarios. These are the reset byte value and the exact results of byte and single-bit writes. They also include the same-cycle races between acknowledge, request and software clear, and the draining of several pending sources one acknowledge at a time.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned CTRL_W = 8;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned SEL_W  = 3;

  localparam logic [SEL_W-1:0] FLAG_POS = 3'd7;
  localparam logic [SEL_W-1:0] MASK_POS = 3'd6;

  typedef struct packed {
    logic              flag;
    logic              mask;
    logic [2:0]        zero;
    logic [PRIO_W-1:0] prio;
  } ctrl_byte_t;

  localparam ctrl_byte_t CTRL_RESET = '{flag: 1'b0, mask: 1'b1, zero: 3'b000, prio: 3'b111};

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_full_i,
  input  logic             wr_bit_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             bit_val_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic             ack_clr_i,
  input  logic             hw_req_i,
  output ctrl_byte_t       ctrl_o
);

  logic              flag_q, flag_d;
  logic              mask_q, mask_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              upd_en;

  // next-state: software write, then acknowledge clear, then hardware set
  always_comb begin
    flag_d = flag_q;
    mask_d = mask_q;
    prio_d = prio_q;
    if (wr_full_i) begin
      flag_d = wdata_i[FLAG_POS];
      mask_d = wdata_i[MASK_POS];
      prio_d = wdata_i[PRIO_W-1:0];
    end else if (wr_bit_i) begin
      case (bit_sel_i)
        FLAG_POS: flag_d = bit_val_i;
        MASK_POS: mask_d = bit_val_i;
        3'd0:     prio_d[0] = bit_val_i;
        3'd1:     prio_d[1] = bit_val_i;
        3'd2:     prio_d[2] = bit_val_i;
        default:  ;
      endcase
    end
    if (ack_clr_i) flag_d = 1'b0;
    if (hw_req_i)  flag_d = 1'b1;
  end

  assign upd_en = wr_full_i | wr_bit_i | ack_clr_i | hw_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= CTRL_RESET.flag;
      mask_q <= CTRL_RESET.mask;
      prio_q <= CTRL_RESET.prio;
    end else if (upd_en) begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      prio_q <= prio_d;
    end
  end

  assign ctrl_o = '{flag: flag_q, mask: mask_q, zero: 3'b000, prio: prio_q};

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned SRC_W  = 3
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    valid_o,
  output logic [SRC_W-1:0]        src_o,
  output logic [PRIO_W-1:0]       lvl_o
);

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    src_o   = '0;
    lvl_o   = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (!valid_o || (prio_i[i*PRIO_W +: PRIO_W] < lvl_o))) begin
        valid_o = 1'b1;
        src_o   = SRC_W'(i);
        lvl_o   = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      irq_req_i,
  input  logic [SRC_W-1:0]      reg_addr_i,
  input  logic                  reg_we_i,
  input  logic                  reg_bitwise_i,
  input  logic [SEL_W-1:0]      reg_bit_sel_i,
  input  logic                  reg_bit_val_i,
  input  logic [CTRL_W-1:0]     reg_wdata_i,
  output logic [CTRL_W-1:0]     reg_rdata_o,
  output logic                  cpu_irq_o,
  output logic [SRC_W-1:0]      cpu_src_o,
  output logic [PRIO_W-1:0]     cpu_lvl_o,
  input  logic                  cpu_ack_i
);

  logic                    rst_sync_n;
  ctrl_byte_t              ctrl_arr [N_SRC];
  logic [N_SRC-1:0]        flag_vec;
  logic [N_SRC-1:0]        mask_vec;
  logic [N_SRC*PRIO_W-1:0] prio_vec;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit;
    logic ack_clr;
    assign hit     = reg_we_i && (reg_addr_i == SRC_W'(i));
    assign ack_clr = cpu_ack_i && cpu_irq_o && (cpu_src_o == SRC_W'(i));

    irq_src_reg u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .wr_full_i (hit && !reg_bitwise_i),
      .wr_bit_i  (hit && reg_bitwise_i),
      .bit_sel_i (reg_bit_sel_i),
      .bit_val_i (reg_bit_val_i),
      .wdata_i   (reg_wdata_i),
      .ack_clr_i (ack_clr),
      .hw_req_i  (irq_req_i[i]),
      .ctrl_o    (ctrl_arr[i])
    );

    assign flag_vec[i] = ctrl_arr[i].flag;
    assign mask_vec[i] = ctrl_arr[i].mask;
    assign prio_vec[i*PRIO_W +: PRIO_W] = ctrl_arr[i].prio;
  end

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb (
    .pend_i  (flag_vec & ~mask_vec),
    .prio_i  (prio_vec),
    .valid_o (cpu_irq_o),
    .src_o   (cpu_src_o),
    .lvl_o   (cpu_lvl_o)
  );

  if (N_SRC == (2 ** SRC_W)) begin : g_rd_full
    assign reg_rdata_o = ctrl_arr[reg_addr_i];
  end else begin : g_rd_guard
    always_comb begin
      reg_rdata_o = '0;
      for (int i = 0; i < N_SRC; i++) begin
        if (reg_addr_i == SRC_W'(i)) reg_rdata_o = ctrl_arr[i];
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned SRC_W = 3
) (
  input logic                 clk_i,
  input logic                 rst_sync_n,
  input logic [N_SRC-1:0]     irq_req_i,
  input logic                 reg_we_i,
  input logic [7:0]           reg_rdata_o,
  input logic                 cpu_irq_o,
  input logic [SRC_W-1:0]     cpu_src_o,
  input logic [2:0]           cpu_lvl_o,
  input logic                 cpu_ack_i,
  input logic [N_SRC-1:0]     flag_vec,
  input logic [N_SRC-1:0]     mask_vec,
  input logic [N_SRC*3-1:0]   prio_vec
);

  // R2
  zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reg_rdata_o[5:3] == 3'b000);

  // R7
  presented_live_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cpu_irq_o |-> (flag_vec[cpu_src_o] && !mask_vec[cpu_src_o]));

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !cpu_irq_o |-> ((flag_vec & ~mask_vec) == '0));

  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cpu_ack_i && cpu_irq_o && !irq_req_i[cpu_src_o] && !reg_we_i)
      |=> !flag_vec[$past(cpu_src_o)]);

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    // R5
    best_level_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (cpu_irq_o && flag_vec[i] && !mask_vec[i]) |-> (prio_vec[i*3 +: 3] >= cpu_lvl_o));

    // R6
    tie_index_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (cpu_irq_o && flag_vec[i] && !mask_vec[i] && (prio_vec[i*3 +: 3] == cpu_lvl_o))
        |-> (SRC_W'(i) >= cpu_src_o));

    // R3
    req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      irq_req_i[i] |=> flag_vec[i]);

    // R4
    masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (flag_vec[i] && mask_vec[i] && !reg_we_i) |=> flag_vec[i]);
  end

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

  localparam int N = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [SW-1:0] addr;
  logic          we, bitwise, bval, ack;
  logic [2:0]    bsel;
  logic [7:0]    wdata, rdata;
  logic          irq;
  logic [SW-1:0] src;
  logic [2:0]    lvl;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .reg_addr_i(addr),
    .reg_we_i(we), .reg_bitwise_i(bitwise), .reg_bit_sel_i(bsel),
    .reg_bit_val_i(bval), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_irq_o(irq), .cpu_src_o(src), .cpu_lvl_o(lvl), .cpu_ack_i(ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    addr = SW'(a);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic irq_is(input int e_irq, input int e_src, input int e_lvl, input string tag);
    #1;
    chk({tag, " irq"}, irq, e_irq);
    if (e_irq != 0) begin
      chk({tag, " src"}, src, e_src);
      chk({tag, " lvl"}, lvl, e_lvl);
    end
  endtask

  task automatic wr_byte(input int a, input int d);
    @(negedge clk);
    addr = SW'(a); wdata = 8'(d); we = 1; bitwise = 0;
    @(negedge clk);
    we = 0;
  endtask

  task automatic wr_bit(input int a, input int s, input int v);
    @(negedge clk);
    addr = SW'(a); bsel = 3'(s); bval = 1'(v); we = 1; bitwise = 1;
    @(negedge clk);
    we = 0; bitwise = 0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) rd(i, 8'h47, "R1 reset byte");
    irq_is(0, 0, 0, "R1 reset");
  endtask

  task automatic t_layout();
    wr_byte(0, 8'hFF);
    rd(0, 8'hC7, "R2 byte write zero field");
    wr_bit(0, 4, 0);
    wr_bit(0, 5, 1);
    rd(0, 8'hC7, "R2 bit write to reserved");
    wr_byte(0, 8'h47);
    rd(0, 8'h47, "R10 full byte write");
  endtask

  task automatic t_mask();
    pulse(8'h02);
    rd(1, 8'hC7, "R3 masked request latched");
    irq_is(0, 0, 0, "R4 masked not presented");
    wr_bit(1, 6, 0);
    rd(1, 8'h87, "R10 bit write mask only");
    irq_is(1, 1, 7, "R4 unmask presents");
    do_ack();
    rd(1, 8'h07, "R8 ack clears flag");
    irq_is(0, 0, 0, "R8 after ack");
  endtask

  task automatic t_prio();
    wr_byte(2, 8'h05);
    wr_byte(3, 8'h02);
    wr_byte(4, 8'h06);
    pulse(8'h1C);
    irq_is(1, 3, 2, "R5 best level");
    do_ack();
    irq_is(1, 2, 5, "R5 second");
    do_ack();
    irq_is(1, 4, 6, "R5 third");
    do_ack();
    irq_is(0, 0, 0, "R7 drained");
  endtask

  task automatic t_tie();
    wr_byte(5, 8'h03);
    wr_byte(6, 8'h03);
    pulse(8'h60);
    irq_is(1, 5, 3, "R6 tie low index");
    do_ack();
    irq_is(1, 6, 3, "R6 tie second");
    do_ack();
    irq_is(0, 0, 0, "R6 drained");
  endtask

  task automatic t_race();
    wr_byte(7, 8'h00);
    pulse(8'h80);
    irq_is(1, 7, 0, "R9 presented");
    @(negedge clk);
    ack = 1; req = 8'h80;
    @(negedge clk);
    ack = 0; req = '0;
    rd(7, 8'h80, "R9 request beats ack");
    irq_is(1, 7, 0, "R9 still presented");
    do_ack();
    rd(7, 8'h00, "R9 cleared later");
  endtask

  task automatic t_ack_idle();
    wr_bit(1, 6, 1);
    pulse(8'h02);
    irq_is(0, 0, 0, "R8 idle setup");
    do_ack();
    rd(1, 8'hC7, "R8 ack without irq no effect");
    wr_byte(1, 8'h47);
  endtask

  task automatic t_sw();
    wr_byte(0, 8'h03);
    wr_bit(0, 7, 1);
    rd(0, 8'h83, "R11 sw set flag");
    irq_is(1, 0, 3, "R11 sw set presents");
    wr_bit(0, 7, 0);
    rd(0, 8'h03, "R11 sw clear flag");
    irq_is(0, 0, 0, "R11 sw clear");
    @(negedge clk);
    addr = 0; bsel = 7; bval = 0; we = 1; bitwise = 1; req = 8'h01;
    @(negedge clk);
    we = 0; bitwise = 0; req = '0;
    rd(0, 8'h83, "R11 hw beats sw clear");
    do_ack();
    rd(0, 8'h03, "R11 final");
  endtask

  initial begin
    rst_n = 0; req = '0; addr = '0; we = 0; bitwise = 0; bsel = '0;
    bval = 0; wdata = '0; ack = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_layout();
    t_mask();
    t_prio();
    t_tie();
    t_race();
    t_ack_idle();
    t_sw();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule